// File: doc/BRIEF.md
# Windowed Watchdog Countdown Timer

This block is a windowed watchdog. Software writes one control byte. The top bit of the byte switches the watchdog on, and the low seven bits load a down-counter. A fixed power-of-two divider and a selectable power-of-two divider pace the counter from the peripheral clock. The block resets the system when bit 6 of the counter falls. That happens on the step from 0x40 to 0x3F, not at zero, so only the low six bits of the loaded value set the usable timeout.

Software must reload the counter before the timeout runs out. A reload must also not arrive too early: a write while the counter is still above a 7-bit window value counts as a premature refresh and causes an immediate reset. The counter value can be read back at all times.

Top module: `wdg_window_timer`

## Requirements
- R1: Out of reset the counter reads 0x7F, the watchdog is off and `wdg_rst` is low.
- R2: A write with `wr_en` high loads `wr_data[6:0]` into the counter. `wr_data[7]` = 1 switches the watchdog on.
- R3: Once on, the watchdog stays on. A later write with `wr_data[7]` = 0 does not stop the counting. Only a watchdog reset or `rst_n` switches it off.
- R4: While on, the counter drops by one every 2^(FIX_LOG2 + `tb_sel`) clock cycles. FIX_LOG2 defaults to 12, giving 4096 cycles per step.
- R5: Every write restarts the divider. The first decrement after a write comes one full step period after the write edge.
- R6: With a loaded value V whose bit 6 is set, the counter reaches 0x3F P·(V[5:0]+1) cycles after the write, where P is the step period. `wdg_rst` is high in the next cycle. Writing 0xFF gives the longest timeout, 64·P.
- R7: A write that switches the watchdog on with bit 6 of the value clear gives a reset pulse in the cycle right after the write.
- R8: A write while the watchdog is on and the counter is above `win_val` gives a reset pulse in the cycle right after the write, and the written byte is discarded. A write with the counter at or below `win_val` is a valid reload.
- R9: `wdg_rst` is high for exactly one cycle. In that same cycle the counter reads 0x7F again and the watchdog is off.
- R10: While the watchdog is off the counter holds its value and no reset pulse occurs.
- R11: `cnt_q` always shows the current 7-bit counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: bit 7 is the enable, bits 6:0 are the counter value |
| win_val | input | 7 | Window compare value |
| tb_sel | input | TB_W (3) | Exponent of the selectable divider |
| wdg_rst | output | 1 | One-cycle watchdog reset pulse |
| cnt_q | output | 7 | Current counter value |

## Verification
The assertions assume that `wr_en` is a single-cycle strobe, and that `tb_sel` and `win_val` are stable around a write. The stimulus drives every input on the falling edge and changes `tb_sel` only while the watchdog is off. It leaves `win_val` at 0x7F except in the window scenario, where it is set before the watchdog is switched on. Writes that should be valid reloads are issued only once the counter is known to be at or below the window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 7;
  localparam logic [CNT_W-1:0] CNT_RST = 7'h7F;

  // last prescaler count before a counter step: 2^sh - 1
  function automatic logic [31:0] last_count(input logic [7:0] sh);
    return (32'd1 << sh) - 32'd1;
  endfunction

  // a refresh is premature while the counter is still above the window
  function automatic logic too_early(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] win);
    return cnt > win;
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int FIX_LOG2 = 12,
  parameter int TB_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [TB_W-1:0] tb_sel,
  output logic            tick
);
  localparam int PRE_W = FIX_LOG2 + (1 << TB_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [31:0]      last;

  assign last = wdg_pkg::last_count(8'(FIX_LOG2) + 8'(tb_sel));
  assign tick = run && ({{(32-PRE_W){1'b0}}, pre_q} == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pre_q <= '0;
    else if (restart || !run || tick) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end

  // R5
  prescaler_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tick,
  input  logic       trip,
  output logic [6:0] cnt_q,
  output logic       active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= wdg_pkg::CNT_RST;
      active_q <= 1'b0;
    end else if (trip) begin
      cnt_q    <= wdg_pkg::CNT_RST;
      active_q <= 1'b0;
    end else if (wr_en) begin
      cnt_q    <= wr_data[6:0];
      active_q <= active_q | wr_data[7];
    end else if (tick) begin
      cnt_q    <= cnt_q - 7'd1;
    end
  end

  // R9
  defaults_after_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (cnt_q == 7'h7F) && !active_q);
  // R3
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !trip) |=> active_q);
  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !trip) |=> (cnt_q == $past(cnt_q) - 7'd1));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_trip.sv
module wdg_trip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [6:0] cnt,
  input  logic       wr_en,
  input  logic [6:0] win_val,
  output logic       trip,
  output logic       rst_pulse_q
);
  logic early_hit;
  logic bit6_low;

  assign early_hit = wr_en && active && wdg_pkg::too_early(cnt, win_val);
  assign bit6_low  = active && !cnt[6];
  assign trip      = early_hit || bit6_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pulse_q <= 1'b0;
    else        rst_pulse_q <= trip;
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_q |=> !rst_pulse_q);
  // R6
  bit6_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $fell(cnt[6])) |=> rst_pulse_q);
  // R8
  early_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && active && (cnt > win_val)) |=> rst_pulse_q);
  // R10
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rst_pulse_q);
endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer #(
  parameter int FIX_LOG2 = 12,
  parameter int TB_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic [6:0]      win_val,
  input  logic [TB_W-1:0] tb_sel,
  output logic            wdg_rst,
  output logic [6:0]      cnt_q
);
  logic tick;
  logic trip;
  logic active;

  wdg_prescaler #(.FIX_LOG2(FIX_LOG2), .TB_W(TB_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(wr_en || trip),
    .tb_sel(tb_sel), .tick(tick));

  wdg_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .trip(trip), .cnt_q(cnt_q), .active_q(active));

  wdg_trip u_trip (
    .clk(clk), .rst_n(rst_n), .active(active), .cnt(cnt_q),
    .wr_en(wr_en), .win_val(win_val), .trip(trip), .rst_pulse_q(wdg_rst));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!wdg_rst || !rst_n));
endmodule

// File: tb/wdg_window_timer_test.sv
`timescale 1ns/1ps
module wdg_window_timer_test;
  localparam int FIX = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [6:0] win_val = 7'h7F;
  logic [2:0] tb_sel = '0;
  logic       wdg_rst;
  logic [6:0] cnt_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdg_window_timer #(.FIX_LOG2(FIX), .TB_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .win_val(win_val), .tb_sel(tb_sel), .wdg_rst(wdg_rst), .cnt_q(cnt_q));

  function automatic int period(input int tb);
    return 1 << (FIX + tb);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_q, 8'h7F);
    chk("R1 rst", wdg_rst, 0);
  endtask

  task automatic t_idle();
    int hits = 0;
    wr(8'h55);
    chk("R2 load", cnt_q, 8'h55);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wdg_rst) hits++;
    end
    chk("R10 hold", cnt_q, 8'h55);
    chk("R10 no pulse", hits, 0);
  endtask

  task automatic t_timeout();
    int p = period(1);
    tb_sel = 3'd1;
    wr(8'hC5);
    chk("R11 readback", cnt_q, 8'h45);
    wait_n(p - 1);
    chk("R4 before step", cnt_q, 8'h45);
    wait_n(1);
    chk("R4 step", cnt_q, 8'h44);
    wait_n(p * 6 - p - 1);
    chk("R6 pre", wdg_rst, 0);
    wait_n(1);
    chk("R6 at 3F", cnt_q, 8'h3F);
    chk("R6 not yet", wdg_rst, 0);
    wait_n(1);
    chk("R6 pulse", wdg_rst, 1);
    chk("R9 cnt default", cnt_q, 8'h7F);
    wait_n(1);
    chk("R9 one cycle", wdg_rst, 0);
    wait_n(p * 2);
    chk("R9 off after pulse", cnt_q, 8'h7F);
  endtask

  task automatic t_restart_sticky();
    int p = period(1);
    wr(8'hC5);
    wait_n(5);
    wr(8'hC6);
    wait_n(p - 1);
    chk("R5 no early step", cnt_q, 8'h46);
    wait_n(1);
    chk("R5 full period", cnt_q, 8'h45);
    wr(8'h70);
    wait_n(p);
    chk("R3 still counting", cnt_q, 8'h6F);
    wr(8'hB0);
    chk("R7 loaded", cnt_q, 8'h30);
    chk("R7 no pulse yet", wdg_rst, 0);
    wait_n(1);
    chk("R7 pulse", wdg_rst, 1);
    chk("R7 cnt default", cnt_q, 8'h7F);
  endtask

  task automatic t_window();
    int p = period(0);
    tb_sel = 3'd0;
    win_val = 7'h50;
    wr(8'hFF);
    wait_n(1);
    wr(8'hFF);
    chk("R8 early pulse", wdg_rst, 1);
    chk("R8 write dropped", cnt_q, 8'h7F);
    wait_n(1);
    chk("R8 pulse ends", wdg_rst, 0);
    wait_n(20);
    chk("R8 off after", cnt_q, 8'h7F);
    wr(8'hD0);
    wait_n(1);
    wr(8'hC8);
    chk("R8 valid reload", cnt_q, 8'h48);
    chk("R8 no pulse", wdg_rst, 0);
    wr(8'hA0);
    wait_n(3);
    win_val = 7'h7F;
    wr(8'hFF);
    wait_n(p * 64 - 1);
    chk("R6 long pre", wdg_rst, 0);
    wait_n(1);
    chk("R6 long at 3F", cnt_q, 8'h3F);
    wait_n(1);
    chk("R6 long pulse", wdg_rst, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_timeout();
    t_restart_sticky();
    t_window();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule